// File: doc/BRIEF.md
# USB Host Root Port Reset and Suspend Control

This block keeps the reset, enable and suspend state of a single root port of a USB 2.0 host controller. Software accesses it through a narrow register path. A write strobe carries a 4-bit control word, and a read word returns the current status. When software starts a port reset, the block raises a request to the physical layer to drive bus reset. When software later asks for the reset to end, the block holds the reset status until the physical layer reports completion. On completion it enables the port automatically if the device was found to be high-speed.

Suspend requests wait for any transaction in progress to finish. Writes of zero to the suspend field are ignored. Suspend is cleared only by specific events: a falling edge of the resume-force field, the start of a port reset, disabling the port, or loss of port power. While the controller is halted, a reset that software has asked to end is held in place. A parameterised count of reference ticks bounds the time between the end request and completion, and a timeout flag marks expiry.

Control word bit positions (write and read): bit 0 port enable, bit 1 force resume, bit 2 suspend, bit 3 port reset.

Top module: `root_port_ctl`

## Requirements
- R1: A write with bit 3 set while bit 3 reads 0 and power is on starts a reset. After that clock edge, bit 3 reads 1, `bus_rst_o` is 1, and the enable (bit 0) and suspend (bit 2) fields read 0.
- R2: After a write with bit 3 clear ends the request, bit 3 and `bus_rst_o` stay 1 until a clock edge where `phy_rst_done_i` is high (and the controller is not halted). They read 0 after that edge.
- R3: At reset completion, the enable bit takes the value of `phy_hs_i`. Software writes of 1 to bit 0 never set it, and a write of 0 clears it.
- R4: After the end request, if `WIN_TICKS` reference ticks pass without completion, `rst_timeout_o` goes to 1, the reset ends and the port stays disabled. The flag clears when the next reset starts.
- R5: While `hc_halted_i` is 1, a reset stays asserted. Completion and reference ticks are ignored until the halt lifts.
- R6: `port_state_o` is 0 (disabled) whenever enable is 0, 1 (enabled) for enable=1 with suspend=0, and 2 (suspended) for enable=1 with suspend=1. All fields read 0 after `rst_ni`.
- R7: A suspend write (bit 2 set) accepted while `xact_busy_i` is 1 leaves bit 2 reading 0 until the first edge with `xact_busy_i` low. Bit 2 reads 1 after that edge.
- R8: A suspend write to an enabled, idle port sets bit 2 after that edge. `block_ds_o` equals the suspended state.
- R9: A write with bit 2 clear does not clear suspend when it leaves enable, reset and force resume unchanged.
- R10: Suspend is cleared by a write that takes bit 1 from 1 to 0, and by a reset start.
- R11: While `port_power_i` is 0, bits 3 and 2 read 0 and `bus_rst_o` and `block_ds_o` are 0. The whole state is cleared, so it remains clear when power returns.
- R12: A suspend write while the port is disabled has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 4 | Control word written |
| rdata_o | output | 4 | Status word read |
| port_power_i | input | 1 | Port power is on |
| hc_halted_i | input | 1 | Host controller halted |
| xact_busy_i | input | 1 | Transaction in progress on the port |
| phy_rst_done_i | input | 1 | Physical layer reports reset finished |
| phy_hs_i | input | 1 | Attached device detected as high-speed |
| tick_i | input | 1 | Reference tick for the completion window |
| bus_rst_o | output | 1 | Request to drive bus reset |
| block_ds_o | output | 1 | Block downstream traffic (port suspended) |
| rst_timeout_o | output | 1 | Completion window expired |
| port_state_o | output | 2 | 0 disabled, 1 enabled, 2 suspended |

## Verification
The hardest conditions to reach are the ones where two timing sources overlap. In one, a reset whose end has been requested is pinned by the halted flag while completion and reference ticks are both present. In the other, a suspend request is parked behind a busy transaction. The bench drives the halted flag with completion and ticks asserted for longer than the window, then lifts the halt. It also sweeps the busy duration after a suspend write, checking that the suspend bit stays clear for every busy cycle and appears exactly one edge after busy drops. A sweep over the tick count before completion covers the exact boundary where the timeout fires.

// File: rtl/root_port_pkg.sv
package root_port_pkg;
  localparam int unsigned RegW    = 4;
  localparam int unsigned EnBit   = 0;
  localparam int unsigned FprBit  = 1;
  localparam int unsigned SuspBit = 2;
  localparam int unsigned RstBit  = 3;

  typedef enum logic [1:0] {
    PS_DISABLED  = 2'd0,
    PS_ENABLED   = 2'd1,
    PS_SUSPENDED = 2'd2
  } port_state_e;
endpackage

// File: rtl/port_rst_seq.sv
module port_rst_seq #(
  parameter int unsigned WIN_TICKS = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwr_i,
  input  logic start_i,
  input  logic stop_i,
  input  logic halted_i,
  input  logic done_i,
  input  logic tick_i,
  output logic active_o,
  output logic finish_o,
  output logic timeout_o
);
  localparam int unsigned CW = (WIN_TICKS < 2) ? 1 : $clog2(WIN_TICKS);
  localparam logic [CW-1:0] LastCnt = CW'(WIN_TICKS - 1);

  logic          active_q, term_q, to_q;
  logic [CW-1:0] cnt_q;
  logic          live, expire;

  // termination is only evaluated while the controller runs
  assign live     = term_q & ~halted_i;
  assign finish_o = live & done_i & pwr_i & ~start_i;
  assign expire   = live & ~done_i & tick_i & (cnt_q == LastCnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      term_q   <= 1'b0;
      to_q     <= 1'b0;
      cnt_q    <= '0;
    end else if (!pwr_i) begin
      active_q <= 1'b0;
      term_q   <= 1'b0;
      to_q     <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      term_q   <= 1'b0;
      to_q     <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (stop_i && active_q && !term_q) begin
        term_q <= 1'b1;
        cnt_q  <= '0;
      end
      if (live) begin
        if (done_i) begin
          active_q <= 1'b0;
          term_q   <= 1'b0;
        end else if (tick_i) begin
          if (expire) begin
            to_q     <= 1'b1;
            active_q <= 1'b0;
            term_q   <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign active_o  = active_q;
  assign timeout_o = to_q;
endmodule

// File: rtl/port_susp_ctl.sv
module port_susp_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic allow_i,
  input  logic busy_i,
  input  logic clr_i,
  output logic susp_o
);
  logic susp_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      susp_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (clr_i) begin
      susp_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (!susp_q) begin
      if (pend_q) begin
        if (!allow_i) begin
          pend_q <= 1'b0;
        end else if (!busy_i) begin
          susp_q <= 1'b1;
          pend_q <= 1'b0;
        end
      end else if (req_i && allow_i) begin
        if (busy_i) pend_q <= 1'b1;
        else        susp_q <= 1'b1;
      end
    end
  end

  assign susp_o = susp_q;
endmodule

// File: rtl/root_port_ctl.sv
module root_port_ctl
  import root_port_pkg::*;
#(
  parameter int unsigned WIN_TICKS = 2000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [RegW-1:0] wdata_i,
  output logic [RegW-1:0] rdata_o,
  input  logic            port_power_i,
  input  logic            hc_halted_i,
  input  logic            xact_busy_i,
  input  logic            phy_rst_done_i,
  input  logic            phy_hs_i,
  input  logic            tick_i,
  output logic            bus_rst_o,
  output logic            block_ds_o,
  output logic            rst_timeout_o,
  output logic [1:0]      port_state_o
);
  logic en_q, fpr_q;
  logic rst_active, rst_finish, susp;
  logic wr_ok, start, stop, fpr_fall, en_clr_wr, susp_clr, allow;
  port_state_e st;

  assign wr_ok     = wr_i & port_power_i;
  assign start     = wr_ok & wdata_i[RstBit] & ~rst_active;
  assign stop      = wr_ok & ~wdata_i[RstBit];
  assign fpr_fall  = wr_ok & fpr_q & ~wdata_i[FprBit];
  assign en_clr_wr = wr_ok & ~wdata_i[EnBit];
  assign susp_clr  = ~port_power_i | start | fpr_fall | en_clr_wr;
  assign allow     = en_q & ~rst_active & port_power_i;

  port_rst_seq #(.WIN_TICKS(WIN_TICKS)) u_rst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwr_i     (port_power_i),
    .start_i   (start),
    .stop_i    (stop),
    .halted_i  (hc_halted_i),
    .done_i    (phy_rst_done_i),
    .tick_i    (tick_i),
    .active_o  (rst_active),
    .finish_o  (rst_finish),
    .timeout_o (rst_timeout_o)
  );

  port_susp_ctl u_susp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (wr_ok & wdata_i[SuspBit]),
    .allow_i (allow),
    .busy_i  (xact_busy_i),
    .clr_i   (susp_clr),
    .susp_o  (susp)
  );

  // enable is set only by hardware at reset completion
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      fpr_q <= 1'b0;
    end else if (!port_power_i) begin
      en_q  <= 1'b0;
      fpr_q <= 1'b0;
    end else begin
      if (start)           en_q <= 1'b0;
      else if (rst_finish) en_q <= phy_hs_i;
      else if (en_clr_wr)  en_q <= 1'b0;
      if (wr_i) fpr_q <= wdata_i[FprBit];
    end
  end

  always_comb begin
    rdata_o          = '0;
    rdata_o[EnBit]   = en_q & port_power_i;
    rdata_o[FprBit]  = fpr_q & port_power_i;
    rdata_o[SuspBit] = susp & port_power_i;
    rdata_o[RstBit]  = rst_active & port_power_i;
  end

  always_comb begin
    if (!(en_q && port_power_i)) st = PS_DISABLED;
    else if (susp)               st = PS_SUSPENDED;
    else                         st = PS_ENABLED;
  end

  assign port_state_o = st;
  assign bus_rst_o    = rst_active & port_power_i;
  assign block_ds_o   = en_q & susp & port_power_i;
endmodule

// File: rtl/root_port_chk.sv
module root_port_chk
  import root_port_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_i,
  input logic [RegW-1:0] wdata_i,
  input logic [RegW-1:0] rdata_o,
  input logic            port_power_i,
  input logic            hc_halted_i,
  input logic            xact_busy_i,
  input logic            phy_rst_done_i,
  input logic            bus_rst_o,
  input logic            rst_timeout_o,
  input logic [1:0]      port_state_o
);
  assert_rst_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wdata_i[RstBit] && !rdata_o[RstBit] && port_power_i
    |=> (bus_rst_o && port_state_o == 2'd0) || !port_power_i);

  assert_rst_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_o && !phy_rst_done_i |=> bus_rst_o || rst_timeout_o || !port_power_i);

  assert_halt_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rst_o && hc_halted_i |=> bus_rst_o || !port_power_i);

  assert_busy_defer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rdata_o[SuspBit] && xact_busy_i |=> !rdata_o[SuspBit]);

  assert_zero_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && !wdata_i[SuspBit] && wdata_i[EnBit] && !wdata_i[RstBit] &&
    (wdata_i[FprBit] || !rdata_o[FprBit]) && rdata_o[SuspBit] && port_power_i
    |=> rdata_o[SuspBit] || !port_power_i);

  assert_power_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_power_i |=> !bus_rst_o && port_state_o == 2'd0);

  assert_disabled_noop_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i && wdata_i[SuspBit] && port_state_o == 2'd0 |=> !rdata_o[SuspBit]);
endmodule

bind root_port_ctl root_port_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_i           (wr_i),
  .wdata_i        (wdata_i),
  .rdata_o        (rdata_o),
  .port_power_i   (port_power_i),
  .hc_halted_i    (hc_halted_i),
  .xact_busy_i    (xact_busy_i),
  .phy_rst_done_i (phy_rst_done_i),
  .bus_rst_o      (bus_rst_o),
  .rst_timeout_o  (rst_timeout_o),
  .port_state_o   (port_state_o)
);

// File: tb/sim_root_port_ctl.sv
`timescale 1ns/1ps
module sim_root_port_ctl;
  localparam int WIN = 6;
  localparam logic [3:0] B_EN = 4'h1, B_FPR = 4'h2, B_SUSP = 4'h4, B_RST = 4'h8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr = 1'b0;
  logic [3:0] wdata = '0, rdata;
  logic pwr = 1'b1, halted = 1'b0, busy = 1'b0, done = 1'b0, hs = 1'b0, tick = 1'b0;
  logic bus_rst, block_ds, tmo;
  logic [1:0] state;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  root_port_ctl #(.WIN_TICKS(WIN)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .port_power_i(pwr), .hc_halted_i(halted), .xact_busy_i(busy),
    .phy_rst_done_i(done), .phy_hs_i(hs), .tick_i(tick),
    .bus_rst_o(bus_rst), .block_ds_o(block_ds), .rst_timeout_o(tmo),
    .port_state_o(state)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_word(input logic [3:0] d);
    wr = 1'b1; wdata = d;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
  endtask

  task automatic do_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic pulse_done(input logic h);
    done = 1'b1; hs = h;
    @(negedge clk);
    done = 1'b0; hs = 1'b0;
  endtask

  task automatic enable_port();
    wr_word(B_RST);
    wr_word(4'h0);
    pulse_done(1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R6 reset rdata", rdata, 4'h0);
    chk("R6 reset state", state, 2'd0);
    chk("R6 reset bus_rst", bus_rst, 1'b0);

    // sweep ticks before completion across the window boundary, both speeds
    for (int h = 0; h < 2; h++) begin
      for (int n = 0; n <= WIN + 1; n++) begin
        wr_word(B_RST);
        chk("R1 rst bit set", rdata[3], 1'b1);
        chk("R1 bus_rst", bus_rst, 1'b1);
        chk("R1 enable cleared", rdata[0], 1'b0);
        chk("R4 flag cleared at start", tmo, 1'b0);
        wr_word(4'h0);
        chk("R2 still reset after end request", rdata[3], 1'b1);
        for (int i = 0; i < n; i++) do_tick();
        if (n < WIN) begin
          chk("R2 held before done", bus_rst, 1'b1);
          chk("R4 no timeout early", tmo, 1'b0);
          pulse_done(h[0]);
          chk("R2 cleared after done", rdata[3], 1'b0);
          chk("R3 enable follows hs", rdata[0], h[0]);
          chk("R6 state after completion", state, h[0] ? 2'd1 : 2'd0);
          wr_word(B_EN | B_FPR);
          chk("R3 write one ignored", rdata[0], h[0]);
          wr_word(B_FPR);
          chk("R3 write zero clears", rdata[0], 1'b0);
          wr_word(4'h0);
        end else begin
          chk("R4 timeout raised", tmo, 1'b1);
          chk("R4 reset ended", bus_rst, 1'b0);
          chk("R4 port disabled", rdata[0], 1'b0);
        end
      end
    end

    // halted hold
    wr_word(B_RST);
    halted = 1'b1;
    wr_word(4'h0);
    done = 1'b1; hs = 1'b1;
    for (int i = 0; i < WIN + 2; i++) do_tick();
    chk("R5 held while halted", bus_rst, 1'b1);
    chk("R5 no timeout while halted", tmo, 1'b0);
    halted = 1'b0;
    @(negedge clk);
    done = 1'b0; hs = 1'b0;
    chk("R5 completes after halt lifts", bus_rst, 1'b0);
    chk("R3 enabled after halt lifts", rdata[0], 1'b1);

    // idle suspend
    wr_word(B_EN | B_SUSP);
    chk("R8 suspend set", rdata[2], 1'b1);
    chk("R8 block_ds", block_ds, 1'b1);
    chk("R6 suspended state", state, 2'd2);
    wr_word(B_EN);
    chk("R9 zero write ignored", rdata[2], 1'b1);
    wr_word(B_EN | B_FPR | B_SUSP);
    chk("R9 fpr set keeps suspend", rdata[2], 1'b1);
    wr_word(B_EN);
    chk("R10 fpr fall clears suspend", rdata[2], 1'b0);
    chk("R10 state enabled", state, 2'd1);
    chk("R8 block_ds low", block_ds, 1'b0);

    // busy sweep
    for (int b = 1; b <= 4; b++) begin
      busy = 1'b1;
      wr_word(B_EN | B_SUSP);
      chk("R7 deferred while busy", rdata[2], 1'b0);
      for (int i = 1; i < b; i++) begin
        @(negedge clk);
        chk("R7 still deferred", rdata[2], 1'b0);
      end
      busy = 1'b0;
      @(negedge clk);
      chk("R7 set after busy drops", rdata[2], 1'b1);
      wr_word(B_EN | B_FPR);
      wr_word(B_EN);
      chk("R10 cleared between sweeps", rdata[2], 1'b0);
    end

    // reset start clears suspend
    wr_word(B_EN | B_SUSP);
    wr_word(B_RST);
    chk("R10 reset start clears suspend", rdata[2], 1'b0);
    chk("R1 reset active from suspend", bus_rst, 1'b1);
    wr_word(4'h0);
    pulse_done(1'b1);

    // disabled suspend
    wr_word(4'h0);
    chk("R6 disabled state", state, 2'd0);
    wr_word(B_SUSP);
    chk("R12 suspend while disabled", rdata[2], 1'b0);
    chk("R12 block_ds", block_ds, 1'b0);

    // power loss
    enable_port();
    wr_word(B_EN | B_SUSP);
    wr_word(B_RST);
    pwr = 1'b0;
    #1;
    chk("R11 rst reads zero", rdata[3], 1'b0);
    chk("R11 bus_rst low", bus_rst, 1'b0);
    @(negedge clk);
    pwr = 1'b1;
    @(negedge clk);
    chk("R11 reset cleared on return", rdata, 4'h0);
    chk("R11 state disabled", state, 2'd0);
    enable_port();
    wr_word(B_EN | B_SUSP);
    pwr = 1'b0;
    #1;
    chk("R11 susp reads zero", rdata[2], 1'b0);
    chk("R11 block_ds low", block_ds, 1'b0);
    @(negedge clk);
    pwr = 1'b1;
    @(negedge clk);
    chk("R11 suspend cleared on return", rdata[2], 1'b0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule